// File: doc/BRIEF.md
# CPU Status and Control Register

This block is the byte-wide status and control register of a small CPU core, placed at one fixed address that every register bank decodes. Software can change only one field in it: the global interrupt disable. The other three fields are flags that hardware events own. One flag reports whether the return-address stack still has room. One is cleared by a watchdog time-out and one is cleared by entry into sleep. The CPU writes the byte through a plain write port. Whatever value it writes, only the interrupt-disable field takes it.

The block also contains the 4-bit return-stack pointer. The call and return logic sends push and pop strobes. The pointer counts modulo 16. When it sits at its top value, the stack-available flag drops. A push that carries the pointer past its top value sets an overflow latch, and only a reset clears that latch. The block also produces a registered global interrupt request. This is the OR of all sources whose request and enable are both high, and it is forced to 0 while interrupts are globally disabled.

Top module: `cpu_status_reg`

## Requirements
- R1: Bits 7, 6, 1 and 0 of `rd_data` always read 0. The used fields are: bit 5 stack available, bit 4 global interrupt disable, bit 3 watchdog time-out flag, bit 2 power-down flag.
- R2: After a synchronous reset, `rd_data` reads 8'h3C and `sp_o` reads 0.
- R3: A write to the register address changes only bit 4, which takes `wr_data[4]` one clock later. Bits 5, 3 and 2 ignore written data.
- R4: Bit 5 reads 0 whenever `sp_o` equals 4'hF.
- R5: A push taken while `sp_o` is 4'hF wraps the pointer to 0 and holds bit 5 at 0 until the next reset, whatever pushes and pops follow.
- R6: When there has been no overflow, a pop that moves the pointer off 4'hF returns bit 5 to 1.
- R7: `sp_o` counts up on a push alone, counts down on a pop alone, wraps modulo 16, and stays the same when push and pop arrive together.
- R8: `clr_wdt` sets bit 3 and `wdt_timeout` clears it. When both arrive in the same cycle, the time-out wins.
- R9: `clr_wdt` sets bit 2 and `sleep_evt` clears it. When both arrive in the same cycle, sleep wins.
- R10: `irq_o` goes 1 one clock after a cycle in which some source has both its request and enable high and the interrupt-disable value being loaded is 0. Otherwise it goes 0. It is never 1 while bit 4 reads 1.
- R11: A write whose `wr_addr` is not the register address (default 8'h06) leaves the register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | CPU write strobe |
| wr_addr | input | ADDR_W (8) | CPU write address |
| wr_data | input | 8 | CPU write data |
| push | input | 1 | Stack push strobe |
| pop | input | 1 | Stack pop strobe |
| clr_wdt | input | 1 | Clear-watchdog event |
| wdt_timeout | input | 1 | Watchdog time-out event |
| sleep_evt | input | 1 | Sleep entry event |
| irq_req | input | NUM_IRQ (8) | Per-source interrupt requests |
| irq_en | input | NUM_IRQ (8) | Per-source interrupt enables |
| rd_data | output | 8 | Register read value |
| sp_o | output | SP_W (4) | Current stack pointer |
| irq_o | output | 1 | Gated, registered interrupt request |

## Verification
The bench walks the pointer down through 4'hF, back up past it, and then across the wrap from 4'hF to 0. A design that did not latch the overflow would show the flag high again after the later pops. A design that latched on reaching 4'hF alone would fail to recover when the pointer moves off the top. The bench also fires clashing events in one cycle (time-out with clear, sleep with clear, a write together with an event) and writes all-ones and all-zeros bytes, so a wrong priority or a writable read-only bit shows up in the read value. Writes to a neighbouring address and the interrupt gate being opened and closed in the same cycle as a pending request are also covered, which catches a gate that uses the disable value from before the write.

// File: rtl/status_pkg.sv
package status_pkg;
  // Bit positions inside the status byte; the decode in software depends on them
  localparam int unsigned POS_STKAV = 5;
  localparam int unsigned POS_GDIS  = 4;
  localparam int unsigned POS_TOUT  = 3;
  localparam int unsigned POS_PDN   = 2;

  typedef struct packed {
    logic stkav;
    logic gdis;
    logic tout;
    logic pdn;
  } stat_fields_t;

  function automatic logic [7:0] pack_status(input stat_fields_t f);
    logic [7:0] b;
    b = '0;
    b[POS_STKAV] = f.stkav;
    b[POS_GDIS]  = f.gdis;
    b[POS_TOUT]  = f.tout;
    b[POS_PDN]   = f.pdn;
    return b;
  endfunction
endpackage

// File: rtl/status_stack_ptr.sv
module status_stack_ptr #(
  parameter int unsigned SP_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            push,
  input  logic            pop,
  output logic [SP_W-1:0] sp_q,
  output logic            stkav
);
  localparam logic [SP_W-1:0] SP_TOP = {SP_W{1'b1}};

  logic ovf_q;
  logic push_only, pop_only;

  assign push_only = push & ~pop;
  assign pop_only  = pop & ~push;

  always_ff @(posedge clk) begin
    if (rst) begin
      sp_q  <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (push_only) begin
        sp_q <= sp_q + 1'b1;
        if (sp_q == SP_TOP) ovf_q <= 1'b1;
      end else if (pop_only) begin
        sp_q <= sp_q - 1'b1;
      end
    end
  end

  assign stkav = ~ovf_q & (sp_q != SP_TOP);
endmodule

// File: rtl/status_event_flags.sv
module status_event_flags #(
  parameter int unsigned ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h06
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              clr_wdt,
  input  logic              wdt_timeout,
  input  logic              sleep_evt,
  output logic              gdis_q,
  output logic              gdis_d,
  output logic              tout_q,
  output logic              pdn_q
);
  import status_pkg::*;

  logic hit;
  assign hit = wr_en & (wr_addr == REG_ADDR);

  always_comb begin
    gdis_d = gdis_q;
    if (hit) gdis_d = wr_data[POS_GDIS];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gdis_q <= 1'b1;
      tout_q <= 1'b1;
      pdn_q  <= 1'b1;
    end else begin
      gdis_q <= gdis_d;
      if (wdt_timeout)  tout_q <= 1'b0;
      else if (clr_wdt) tout_q <= 1'b1;
      if (sleep_evt)    pdn_q  <= 1'b0;
      else if (clr_wdt) pdn_q  <= 1'b1;
    end
  end
endmodule

// File: rtl/status_irq_gate.sv
module status_irq_gate #(
  parameter int unsigned NUM_IRQ = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               gdis_next,
  input  logic [NUM_IRQ-1:0] irq_req,
  input  logic [NUM_IRQ-1:0] irq_en,
  output logic               irq_o
);
  logic [NUM_IRQ-1:0] live;

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_src
    assign live[i] = irq_req[i] & irq_en[i];
  end

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= ~gdis_next & (|live);
  end
endmodule

// File: rtl/cpu_status_reg.sv
module cpu_status_reg #(
  parameter int unsigned ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h06,
  parameter int unsigned SP_W     = 4,
  parameter int unsigned NUM_IRQ  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [7:0]         wr_data,
  input  logic               push,
  input  logic               pop,
  input  logic               clr_wdt,
  input  logic               wdt_timeout,
  input  logic               sleep_evt,
  input  logic [NUM_IRQ-1:0] irq_req,
  input  logic [NUM_IRQ-1:0] irq_en,
  output logic [7:0]         rd_data,
  output logic [SP_W-1:0]    sp_o,
  output logic               irq_o
);
  import status_pkg::*;

  logic gdis_q, gdis_d, tout_q, pdn_q, stkav;
  stat_fields_t f;

  status_stack_ptr #(.SP_W(SP_W)) u_sp (
    .clk(clk), .rst(rst), .push(push), .pop(pop),
    .sp_q(sp_o), .stkav(stkav)
  );

  status_event_flags #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_flags (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .clr_wdt(clr_wdt), .wdt_timeout(wdt_timeout), .sleep_evt(sleep_evt),
    .gdis_q(gdis_q), .gdis_d(gdis_d), .tout_q(tout_q), .pdn_q(pdn_q)
  );

  status_irq_gate #(.NUM_IRQ(NUM_IRQ)) u_gate (
    .clk(clk), .rst(rst), .gdis_next(gdis_d),
    .irq_req(irq_req), .irq_en(irq_en), .irq_o(irq_o)
  );

  assign f.stkav = stkav;
  assign f.gdis  = gdis_q;
  assign f.tout  = tout_q;
  assign f.pdn   = pdn_q;
  assign rd_data = pack_status(f);
endmodule

// File: rtl/cpu_status_reg_chk.sv
module cpu_status_reg_chk #(
  parameter int unsigned SP_W = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            push,
  input logic            pop,
  input logic            clr_wdt,
  input logic            wdt_timeout,
  input logic            sleep_evt,
  input logic [7:0]      rd_data,
  input logic [SP_W-1:0] sp_o,
  input logic            irq_o
);
  localparam logic [SP_W-1:0] TOP = {SP_W{1'b1}};

  a_r1_unused_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_data[7:6] == 2'b00) && (rd_data[1:0] == 2'b00));

  a_r4_full_flag: assert property (@(posedge clk) disable iff (rst)
    (sp_o == TOP) |-> !rd_data[5]);

  a_r5_sticky: assert property (@(posedge clk) disable iff (rst)
    (!rd_data[5] && sp_o != TOP) |=> !rd_data[5]);

  a_r7_push: assert property (@(posedge clk) disable iff (rst)
    (push && !pop) |=> sp_o == SP_W'($past(sp_o) + 1'b1));

  a_r7_both: assert property (@(posedge clk) disable iff (rst)
    (push && pop) |=> $stable(sp_o));

  a_r8_timeout: assert property (@(posedge clk) disable iff (rst)
    wdt_timeout |=> !rd_data[3]);

  a_r3_tout_hold: assert property (@(posedge clk) disable iff (rst)
    (!wdt_timeout && !clr_wdt) |=> $stable(rd_data[3]));

  a_r9_sleep: assert property (@(posedge clk) disable iff (rst)
    sleep_evt |=> !rd_data[2]);

  a_r10_gate: assert property (@(posedge clk) disable iff (rst)
    rd_data[4] |-> !irq_o);
endmodule

bind cpu_status_reg cpu_status_reg_chk #(.SP_W(SP_W)) u_chk (
  .clk(clk), .rst(rst), .push(push), .pop(pop), .clr_wdt(clr_wdt),
  .wdt_timeout(wdt_timeout), .sleep_evt(sleep_evt),
  .rd_data(rd_data), .sp_o(sp_o), .irq_o(irq_o)
);

// File: tb/test_cpu_status_reg.sv
`timescale 1ns/1ps
module test_cpu_status_reg;
  logic clk = 1'b0, rst = 1'b1;
  logic wr_en = 1'b0, push = 1'b0, pop = 1'b0;
  logic clr_wdt = 1'b0, wdt_timeout = 1'b0, sleep_evt = 1'b0;
  logic [7:0] wr_addr = 8'h06, wr_data = 8'h00;
  logic [7:0] irq_req = 8'h00, irq_en = 8'h00;
  logic [7:0] rd_data;
  logic [3:0] sp_o;
  logic irq_o;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  cpu_status_reg i_cpu_status_reg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .push(push), .pop(pop), .clr_wdt(clr_wdt), .wdt_timeout(wdt_timeout),
    .sleep_evt(sleep_evt), .irq_req(irq_req), .irq_en(irq_en),
    .rd_data(rd_data), .sp_o(sp_o), .irq_o(irq_o)
  );

  // {push, pop, wr, wdata[7:0], clr, tmo, slp, exp_rd[7:0], exp_sp[3:0]}
  localparam int NV = 18;
  localparam logic [25:0] VEC [NV] = '{
    {3'b001, 8'h00, 3'b000, 8'h2C, 4'h0},  // R3 write clears gdis only
    {3'b001, 8'hFF, 3'b000, 8'h3C, 4'h0},  // R3 ones do not touch flags
    {3'b000, 8'h00, 3'b010, 8'h34, 4'h0},  // R8 time-out
    {3'b000, 8'h00, 3'b001, 8'h30, 4'h0},  // R9 sleep
    {3'b000, 8'h00, 3'b100, 8'h3C, 4'h0},  // R8 R9 clear
    {3'b000, 8'h00, 3'b110, 8'h34, 4'h0},  // R8 time-out wins
    {3'b000, 8'h00, 3'b101, 8'h38, 4'h0},  // R9 sleep wins
    {3'b001, 8'h00, 3'b100, 8'h2C, 4'h0},  // R3 write with event
    {3'b100, 8'h00, 3'b000, 8'h2C, 4'h1},  // R7 push
    {3'b110, 8'h00, 3'b000, 8'h2C, 4'h1},  // R7 push and pop
    {3'b010, 8'h00, 3'b000, 8'h2C, 4'h0},  // R7 pop
    {3'b010, 8'h00, 3'b000, 8'h0C, 4'hF},  // R4 R7 wrap down to top
    {3'b010, 8'h00, 3'b000, 8'h2C, 4'hE},  // R6 recovers
    {3'b100, 8'h00, 3'b000, 8'h0C, 4'hF},  // R4 top again
    {3'b100, 8'h00, 3'b000, 8'h0C, 4'h0},  // R5 overflow
    {3'b010, 8'h00, 3'b000, 8'h0C, 4'hF},  // R5
    {3'b010, 8'h00, 3'b000, 8'h0C, 4'hE},  // R5 sticky
    {3'b010, 8'h00, 3'b000, 8'h0C, 4'hD}   // R5 sticky
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    push = 0; pop = 0; wr_en = 0; clr_wdt = 0; wdt_timeout = 0; sleep_evt = 0;
    wr_addr = 8'h06;
  endtask

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;
    chk("R2 reset value", rd_data, 8'h3C);
    chk("R2 reset pointer", {4'h0, sp_o}, 8'h00);
    chk("R1 R10 irq idle", {7'h0, irq_o}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      {push, pop, wr_en, wr_data, clr_wdt, wdt_timeout, sleep_evt} = VEC[i][25:12];
      @(negedge clk);
      chk($sformatf("R1/R3/R5/R6/R8/R9 row %0d rd", i), rd_data, VEC[i][11:4]);
      chk($sformatf("R4/R7 row %0d sp", i), {4'h0, sp_o}, {4'h0, VEC[i][3:0]});
      idle_inputs();
    end

    // reset clears the overflow latch
    rst = 1; @(negedge clk); rst = 0;
    chk("R2 R5 reset after overflow", rd_data, 8'h3C);
    chk("R2 pointer after reset", {4'h0, sp_o}, 8'h00);

    // write to a neighbouring address
    wr_en = 1; wr_addr = 8'h07; wr_data = 8'h00; @(negedge clk); idle_inputs();
    chk("R11 other address ignored", rd_data, 8'h3C);

    // interrupt gate
    irq_req = 8'h40; irq_en = 8'h40; @(negedge clk);
    chk("R10 blocked while disabled", {7'h0, irq_o}, 8'h00);
    wr_en = 1; wr_data = 8'h00; @(negedge clk); idle_inputs();
    chk("R10 opens with write", {7'h0, irq_o}, 8'h01);
    irq_en = 8'h01; @(negedge clk);
    chk("R10 source not enabled", {7'h0, irq_o}, 8'h00);
    irq_en = 8'hFF; @(negedge clk);
    chk("R10 enabled source passes", {7'h0, irq_o}, 8'h01);
    wr_en = 1; wr_data = 8'h10; @(negedge clk); idle_inputs();
    chk("R10 closes with write", {7'h0, irq_o}, 8'h00);
    chk("R3 gdis set by write", rd_data, 8'h3C);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule